// File: doc/BRIEF.md
# Serial Channel Transmit/Receive Buffering

This block holds the bytes that travel between a host register port and the transmit and receive shift registers of a serial channel. The host writes bytes for transmission and reads received bytes. On the line side, the transmit shifter takes a byte whenever it reports that it is empty. The receive shifter hands over a byte each time it completes a frame.

The amount of storage in each direction is chosen at run time. On the transmit side a cleared buffering bit gives pass-through operation, and a set bit gives one holding stage. On the receive side there is always one holding stage. A receive stage with single buffering stalls the shifter while it is occupied, and a stage with double buffering drops the byte that arrives while it is full. When buffering is on and the FIFO enable is set, a queue of FIFO_DEPTH byte stages replaces the holding stage. The queue serves transmit, receive, or both, and in the last case each direction gets half of it. Any change of mode or configuration empties every stage and clears the error flags.

Top module: `serial_chan_buf`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, tx_err, rx_ovr, rx_err and tx_load are 0.
- R2: With wbuf=0 a host write goes straight to the shifter: tx_load=1 and tx_load_data=host_wdata in the same cycle when tx_shift_empty=1. A write while tx_shift_empty=0 is dropped and sets tx_err.
- R3: With wbuf=1 and no transmit FIFO, transmit holds one byte. The byte is loaded (tx_load=1, data=held byte) in a cycle with tx_shift_empty=1. A write while the stage is full is dropped and sets tx_err.
- R4: Receive double buffering is forced in every mode except mode 2'b01 (clock output); in that mode it follows wbuf. rx_hold=1 exactly when single buffering is in effect and the receive stage is full.
- R5: A rx_done while the receive storage is full, with no read in that cycle, drops the new byte, leaves level and held data unchanged, and sets the sticky rx_ovr.
- R6: The FIFO is used only when wbuf=1 and fifo_cfg_en=1. With wbuf=0 the transmit capacity is 0 and the receive capacity is 1, whatever fifo_cfg_en and fifo_assign are.
- R7: fifo_assign 2'b01 gives transmit FIFO_DEPTH stages, 2'b10 gives receive FIFO_DEPTH stages, 2'b11 gives each direction FIFO_DEPTH/2 stages, and 2'b00 gives no FIFO.
- R8: Each direction delivers bytes in write order. The level counts the held bytes (0..capacity), with full meaning level equals capacity and empty meaning level is 0. host_rdata shows the oldest received byte.
- R9: A host read while receive is empty is ignored and sets the sticky rx_err. A host write while transmit is full is ignored and sets tx_err.
- R10: A change of any of mode, wbuf, fifo_cfg_en or fifo_assign empties both directions and clears tx_err, rx_ovr and rx_err at the next clock edge. Host and shifter events in that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 UART, 01 sync clock output, 10 sync clock input, 11 treated as clock input |
| wbuf | input | 1 | Buffering enable |
| fifo_cfg_en | input | 1 | FIFO enable (effective only with wbuf) |
| fifo_assign | input | 2 | FIFO assignment: 00 none, 01 tx, 10 rx, 11 split |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write byte |
| host_rd | input | 1 | Host read strobe (pops oldest byte) |
| host_rdata | output | DATA_W | Oldest received byte |
| tx_shift_empty | input | 1 | Transmit shifter can accept a byte |
| tx_load | output | 1 | Byte handed to transmit shifter this cycle |
| tx_load_data | output | DATA_W | Byte handed to transmit shifter |
| rx_done | input | 1 | Receive shifter completed a frame |
| rx_shift_data | input | DATA_W | Byte from receive shifter |
| rx_hold | output | 1 | Stall request to receive shifter (single buffering, stage full) |
| tx_level | output | clog2(FIFO_DEPTH+1) | Bytes held for transmit |
| tx_full | output | 1 | Transmit cannot take a write |
| tx_empty | output | 1 | Transmit holds nothing |
| rx_level | output | clog2(FIFO_DEPTH+1) | Bytes held from receive |
| rx_full | output | 1 | Receive storage full |
| rx_empty | output | 1 | Receive storage empty |
| tx_err | output | 1 | Sticky: transmit write dropped |
| rx_ovr | output | 1 | Sticky: receive frame dropped |
| rx_err | output | 1 | Sticky: read while empty |

## Verification
The hardest situation to reach is a push and a pop in the same cycle on a full queue whose capacity was shrunk by a split assignment. This is where an off-by-one capacity or ordering error would show. The bench reaches it by sweeping all 64 configuration codes. Under each code it runs random cycles with heavy write and frame rates and a shifter that is often busy, so the queues sit at capacity. Directed sequences first cover the split capacity, the receive stall, the overrun and the flush.

// File: rtl/serial_chan_buf_pkg.sv
package serial_chan_buf_pkg;

  typedef enum logic [1:0] {
    MODE_UART        = 2'b00,
    MODE_SYNC_CLKOUT = 2'b01,
    MODE_SYNC_CLKIN  = 2'b10,
    MODE_RSVD        = 2'b11
  } chan_mode_e;

  typedef enum logic [1:0] {
    FA_NONE  = 2'b00,
    FA_TX    = 2'b01,
    FA_RX    = 2'b10,
    FA_SPLIT = 2'b11
  } fifo_assign_e;

  // Receive side keeps double buffering except when the clock is generated locally.
  function automatic logic rx_double_forced(input logic [1:0] mode);
    return mode != MODE_SYNC_CLKOUT;
  endfunction

  // Number of byte stages a direction may hold.
  function automatic int unsigned dir_capacity(input logic fifo_on, input logic split,
                                               input logic dbl, input int unsigned depth);
    if (fifo_on) return split ? depth / 2 : depth;
    return dbl ? 1 : 0;
  endfunction

endpackage

// File: rtl/scb_cfg_decode.sv
module scb_cfg_decode
  import serial_chan_buf_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input  logic [1:0]       mode,
  input  logic             wbuf,
  input  logic             fifo_cfg_en,
  input  logic [1:0]       fifo_assign,
  output logic [LVL_W-1:0] cap_tx,
  output logic [LVL_W-1:0] cap_rx,
  output logic             rx_dbl,
  output logic             tx_bypass
);
  logic fifo_ok, tx_fifo, rx_fifo, split;

  always_comb begin
    fifo_ok   = wbuf & fifo_cfg_en;
    tx_fifo   = fifo_ok & fifo_assign[0];
    rx_fifo   = fifo_ok & fifo_assign[1];
    split     = fifo_assign == FA_SPLIT;
    rx_dbl    = wbuf | rx_double_forced(mode);
    // receive always owns at least one stage; single vs double differs in stall/overrun
    cap_tx    = LVL_W'(dir_capacity(tx_fifo, split, wbuf, FIFO_DEPTH));
    cap_rx    = LVL_W'(dir_capacity(rx_fifo, split, 1'b1, FIFO_DEPTH));
    tx_bypass = cap_tx == '0;
  end
endmodule

// File: rtl/scb_queue.sv
module scb_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [LVL_W-1:0]  cap,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  count,
  output logic              push_rej,
  output logic              pop_rej
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok  = push & (count < cap);
  assign pop_ok   = pop & (count != '0);
  assign push_rej = push & ~push_ok;
  assign pop_rej  = pop & ~pop_ok;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/serial_chan_buf.sv
module serial_chan_buf #(
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      mode,
  input  logic                            wbuf,
  input  logic                            fifo_cfg_en,
  input  logic [1:0]                      fifo_assign,
  input  logic                            host_wr,
  input  logic [DATA_W-1:0]               host_wdata,
  input  logic                            host_rd,
  output logic [DATA_W-1:0]               host_rdata,
  input  logic                            tx_shift_empty,
  output logic                            tx_load,
  output logic [DATA_W-1:0]               tx_load_data,
  input  logic                            rx_done,
  input  logic [DATA_W-1:0]               rx_shift_data,
  output logic                            rx_hold,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] tx_level,
  output logic                            tx_full,
  output logic                            tx_empty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
  output logic                            rx_full,
  output logic                            rx_empty,
  output logic                            tx_err,
  output logic                            rx_ovr,
  output logic                            rx_err
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int CFG_W = 6;

  logic [LVL_W-1:0]  cap_tx, cap_rx;
  logic              rx_dbl, tx_bypass;
  logic [CFG_W-1:0]  cfg_now, cfg_q;
  logic              cfg_change;
  logic              tx_push, tx_pop, tx_push_rej, tx_pop_rej;
  logic              rx_push, rx_pop, rx_push_rej, rx_pop_rej;
  logic [DATA_W-1:0] tx_head;
  logic              tx_drop_ev;

  scb_cfg_decode #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) dec_i (
    .mode(mode), .wbuf(wbuf), .fifo_cfg_en(fifo_cfg_en), .fifo_assign(fifo_assign),
    .cap_tx(cap_tx), .cap_rx(cap_rx), .rx_dbl(rx_dbl), .tx_bypass(tx_bypass)
  );

  // configuration tracking: any change empties everything
  assign cfg_now    = {mode, wbuf, fifo_cfg_en, fifo_assign};
  assign cfg_change = cfg_now != cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  // transmit path
  assign tx_push = host_wr & ~tx_bypass & ~cfg_change;
  assign tx_pop  = tx_load & ~tx_bypass;
  assign tx_load = ~cfg_change & tx_shift_empty & (tx_bypass ? host_wr : (tx_level != '0));
  assign tx_load_data = tx_bypass ? host_wdata : tx_head;

  scb_queue #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) txq_i (
    .clk(clk), .rst_n(rst_n), .flush(cfg_change), .cap(cap_tx),
    .push(tx_push), .push_data(host_wdata), .pop(tx_pop),
    .head(tx_head), .count(tx_level), .push_rej(tx_push_rej), .pop_rej(tx_pop_rej)
  );

  assign tx_drop_ev = ~cfg_change & host_wr & (tx_bypass ? ~tx_shift_empty : tx_push_rej);
  assign tx_full    = tx_bypass ? ~tx_shift_empty : (tx_level == cap_tx);
  assign tx_empty   = tx_level == '0;

  // receive path
  assign rx_push = rx_done & ~cfg_change;
  assign rx_pop  = host_rd & ~cfg_change;

  scb_queue #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) rxq_i (
    .clk(clk), .rst_n(rst_n), .flush(cfg_change), .cap(cap_rx),
    .push(rx_push), .push_data(rx_shift_data), .pop(rx_pop),
    .head(host_rdata), .count(rx_level), .push_rej(rx_push_rej), .pop_rej(rx_pop_rej)
  );

  assign rx_full  = rx_level == cap_rx;
  assign rx_empty = rx_level == '0;
  assign rx_hold  = ~rx_dbl & rx_full;

  // sticky error flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_err <= 1'b0;
      rx_ovr <= 1'b0;
      rx_err <= 1'b0;
    end else if (cfg_change) begin
      tx_err <= 1'b0;
      rx_ovr <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      if (tx_drop_ev)  tx_err <= 1'b1;
      if (rx_push_rej) rx_ovr <= 1'b1;
      if (rx_pop_rej)  rx_err <= 1'b1;
    end
  end
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             wbuf,
  input logic             cfg_change,
  input logic [LVL_W-1:0] cap_tx,
  input logic [LVL_W-1:0] cap_rx,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_load,
  input logic             tx_shift_empty,
  input logic             rx_done,
  input logic             rx_full,
  input logic             rx_hold,
  input logic             host_rd,
  input logic             tx_err,
  input logic             rx_ovr,
  input logic             rx_err
);
  AST_TX_LOAD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_shift_empty); // R2
  AST_RX_HOLD_ONLY_CLKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hold |-> (mode == 2'b01 && !wbuf)); // R4
  AST_OVERRUN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !host_rd && !cfg_change) |=> (rx_ovr && $stable(rx_level))); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !cfg_change) |=> rx_ovr); // R5
  AST_NO_FIFO_WITHOUT_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    !wbuf |-> (cap_tx == '0 && cap_rx == LVL_W'(1))); // R6
  AST_LEVEL_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_change |-> (tx_level <= cap_tx && rx_level <= cap_rx)); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (tx_level == '0 && rx_level == '0 && !tx_err && !rx_ovr && !rx_err)); // R10
endmodule

bind serial_chan_buf scb_checker #(.LVL_W($clog2(FIFO_DEPTH + 1))) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .wbuf(wbuf), .cfg_change(cfg_change),
  .cap_tx(cap_tx), .cap_rx(cap_rx), .tx_level(tx_level), .rx_level(rx_level),
  .tx_load(tx_load), .tx_shift_empty(tx_shift_empty), .rx_done(rx_done),
  .rx_full(rx_full), .rx_hold(rx_hold), .host_rd(host_rd),
  .tx_err(tx_err), .rx_ovr(rx_ovr), .rx_err(rx_err)
);

// File: tb/serial_chan_buf_tb.sv
`timescale 1ns/1ps
module serial_chan_buf_tb_top;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic       wbuf = 1'b0, fifo_cfg_en = 1'b0;
  logic [1:0] fifo_assign = '0;
  logic       host_wr = 0, host_rd = 0, tx_shift_empty = 0, rx_done = 0;
  logic [7:0] host_wdata = '0, rx_shift_data = '0;
  logic [7:0] host_rdata, tx_load_data;
  logic       tx_load, rx_hold, tx_full, tx_empty, rx_full, rx_empty, tx_err, rx_ovr, rx_err;
  logic [2:0] tx_level, rx_level;

  serial_chan_buf #(.FIFO_DEPTH(D), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wbuf(wbuf), .fifo_cfg_en(fifo_cfg_en),
    .fifo_assign(fifo_assign), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .tx_shift_empty(tx_shift_empty),
    .tx_load(tx_load), .tx_load_data(tx_load_data), .rx_done(rx_done),
    .rx_shift_data(rx_shift_data), .rx_hold(rx_hold), .tx_level(tx_level),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_level(rx_level), .rx_full(rx_full),
    .rx_empty(rx_empty), .tx_err(tx_err), .rx_ovr(rx_ovr), .rx_err(rx_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  byte unsigned txq[$], rxq[$];
  bit m_txerr, m_rxovr, m_rxerr;
  logic [5:0] pcfg = '0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_cap_tx();
    if (!wbuf) return 0;
    if (!fifo_cfg_en) return 1;
    case (fifo_assign)
      2'b01: return D;
      2'b11: return D / 2;
      default: return 1;
    endcase
  endfunction

  function automatic int m_cap_rx();
    if (!(wbuf && fifo_cfg_en)) return 1;
    case (fifo_assign)
      2'b10: return D;
      2'b11: return D / 2;
      default: return 1;
    endcase
  endfunction

  function automatic bit m_rx_single();
    return (mode == 2'b01) && !wbuf;
  endfunction

  task automatic step(input bit wr, input byte unsigned wd, input bit rd,
                      input bit dn, input byte unsigned rdv, input bit se);
    bit flush, byp, exp_load;
    int ct, cr, tpre, rpre;
    host_wr = wr; host_wdata = wd; host_rd = rd;
    rx_done = dn; rx_shift_data = rdv; tx_shift_empty = se;
    #1;
    flush = {mode, wbuf, fifo_cfg_en, fifo_assign} != pcfg;
    ct = m_cap_tx(); cr = m_cap_rx(); byp = (ct == 0);
    exp_load = !flush && se && (byp ? wr : txq.size() > 0);
    chk(tx_load == exp_load, byp ? "R2" : "R3", "tx_load", tx_load, exp_load);
    if (exp_load)
      chk(tx_load_data == (byp ? wd : txq[0]), byp ? "R2" : "R3", "tx_load_data",
          tx_load_data, byp ? wd : txq[0]);
    chk(rx_hold == (m_rx_single() && rxq.size() == cr), "R4", "rx_hold", rx_hold,
        m_rx_single() && rxq.size() == cr);
    if (rxq.size() > 0) chk(host_rdata == rxq[0], "R8", "host_rdata", host_rdata, rxq[0]);
    chk(int'(tx_level) == txq.size(), "R8", "tx_level", tx_level, txq.size());
    chk(int'(rx_level) == rxq.size(), "R8", "rx_level", rx_level, rxq.size());
    chk(tx_empty == (txq.size() == 0), "R8", "tx_empty", tx_empty, txq.size() == 0);
    chk(rx_empty == (rxq.size() == 0), "R8", "rx_empty", rx_empty, rxq.size() == 0);
    chk(rx_full == (rxq.size() == cr), "R8", "rx_full", rx_full, rxq.size() == cr);
    chk(tx_full == (byp ? !se : txq.size() == ct), "R8", "tx_full", tx_full,
        byp ? !se : txq.size() == ct);
    chk(tx_err == m_txerr, "R9", "tx_err", tx_err, m_txerr);
    chk(rx_ovr == m_rxovr, "R5", "rx_ovr", rx_ovr, m_rxovr);
    chk(rx_err == m_rxerr, "R9", "rx_err", rx_err, m_rxerr);
    // model update for the coming edge
    if (flush) begin
      txq.delete(); rxq.delete();
      m_txerr = 0; m_rxovr = 0; m_rxerr = 0;
    end else begin
      tpre = txq.size();
      if (byp) begin
        if (wr && !se) m_txerr = 1;
      end else begin
        if (exp_load) void'(txq.pop_front());
        if (wr) begin
          if (tpre < ct) txq.push_back(wd); else m_txerr = 1;
        end
      end
      rpre = rxq.size();
      if (rd) begin
        if (rpre > 0) void'(rxq.pop_front()); else m_rxerr = 1;
      end
      if (dn) begin
        if (rpre < cr) rxq.push_back(rdv); else m_rxovr = 1;
      end
    end
    pcfg = {mode, wbuf, fifo_cfg_en, fifo_assign};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input bit w, input bit c, input logic [1:0] a);
    mode = m; wbuf = w; fifo_cfg_en = c; fifo_assign = a;
    step(0, 0, 0, 0, 0, 0); // flush cycle
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(tx_level == 0 && rx_level == 0, "R1", "levels", {tx_level, rx_level}, 0);
    chk(tx_empty && rx_empty, "R1", "empty flags", {tx_empty, rx_empty}, 3);
    chk(!tx_err && !rx_ovr && !rx_err && !tx_load, "R1", "flags", {tx_err, rx_ovr, rx_err, tx_load}, 0);
    @(negedge clk);

    // R2 pass-through transmit
    set_cfg(2'b00, 0, 0, 2'b00);
    step(1, 8'hA5, 0, 0, 0, 1);
    step(1, 8'h3C, 0, 0, 0, 0);
    chk(tx_err == 1, "R2", "write while shifter busy", tx_err, 1);

    // R3 one transmit stage
    set_cfg(2'b00, 1, 0, 2'b00);
    step(1, 8'h11, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    chk(tx_err == 1 && tx_level == 1, "R3", "second write dropped", {tx_err, tx_level}, 9);
    step(0, 0, 0, 0, 0, 1);

    // R6 FIFO enable ignored without buffering
    set_cfg(2'b00, 0, 1, 2'b11);
    step(1, 8'h01, 0, 1, 8'h55, 0);
    step(1, 8'h02, 0, 1, 8'h66, 0);
    chk(tx_level == 0 && rx_level == 1, "R6", "no FIFO capacity", {tx_level, rx_level}, 1);

    // R7 split capacity, R5 overrun
    set_cfg(2'b00, 1, 1, 2'b11);
    for (int i = 0; i < 3; i++) step(1, 8'h40 + i, 0, 1, 8'h80 + i, 0);
    chk(tx_level == 2 && rx_level == 2, "R7", "split levels", {tx_level, rx_level}, 18);
    chk(rx_ovr == 1 && host_rdata == 8'h80, "R5", "overrun keeps data", host_rdata, 8'h80);

    // R4 single receive stalls in clock-output mode only
    set_cfg(2'b01, 0, 0, 2'b00);
    step(0, 0, 0, 1, 8'h77, 0);
    chk(rx_hold == 1, "R4", "rx_hold clkout single", rx_hold, 1);
    set_cfg(2'b10, 0, 0, 2'b00);
    step(0, 0, 0, 1, 8'h78, 0);
    chk(rx_hold == 0, "R4", "rx_hold clkin forced double", rx_hold, 0);

    // R8 receive FIFO order and full flag, R9 read when empty
    set_cfg(2'b00, 1, 1, 2'b10);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 8'hC0 + i, 0);
    chk(rx_full == 1 && rx_level == 4, "R8", "rx full at depth", rx_level, 4);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0);
    chk(rx_err == 1 && rx_empty == 1, "R9", "read when empty", rx_err, 1);

    // R10 flush on configuration change
    step(1, 8'h99, 0, 1, 8'h98, 0);
    set_cfg(2'b00, 1, 1, 2'b01);
    chk(tx_level == 0 && rx_level == 0 && !rx_err, "R10", "flushed", {tx_level, rx_level, rx_err}, 0);

    // random sweep over every configuration code
    for (int c = 0; c < 64; c++) begin
      set_cfg(c[5:4], c[3], c[2], c[1:0]);
      for (int k = 0; k < 150; k++)
        step(($urandom % 10) < 5, 8'($urandom), ($urandom % 10) < 3,
             ($urandom % 10) < 4, 8'($urandom), ($urandom % 10) < 4);
    end

    finish_run();
  end
endmodule